// File: doc/BRIEF.md
# Multiplexer-Molecule Cell Execution Unit

This block is the combinational datapath of one cell in a grid of identical cells. Each cell takes a 3-bit bus from its west neighbour and another from its north neighbour. It drives 3-bit buses toward its east and south neighbours. Data only moves east and south, so a grid of such cells has no combinational loop. A 2-bit cell state comes in as well. State zero marks a dead cell, which forwards its inputs unchanged. The three live states are fed into the logic as ordinary signals, so one configuration can act differently in each live state.

The logic is a feed-forward chain of eight molecules. Each molecule is a 2:1 multiplexer with three inputs A, B and C, and C chooses between A and B. A molecule runs in one of four variants, which differ in whether A and/or B is inverted. No molecule input can be tied to a constant, so a fixed 0 or 1 has to come from an upstream molecule. Six output taps pick any source signal for each east and south bit.

The configuration genotype is 136 bits. It enters one bit per clock into a shadow register. It becomes active only when a load strobe copies the shadow into the working register. While a new genotype is being shifted in, the datapath keeps its old behaviour.

Top module: `cell_eu`

## Requirements
- R1: After reset the active genotype is all zeros. In any live state (1 to 3), every bit of east_o and south_o then equals west_i[0].
- R2: In state 0, east_o equals west_i and south_o equals north_i, whatever genotype is loaded.
- R3: A molecule with variant code v evaluates as follows. When C is 0 it outputs A, inverted if v[1] is 1. When C is 1 it outputs B, inverted if v[0] is 1. So 00 = A·C'+B·C, 01 = A·C'+B'·C, 10 = A'·C'+B·C and 11 = A'·C'+B'·C.
- R4: A variant-01 molecule with one signal on all three inputs always outputs 0. A variant-10 molecule wired the same way always outputs 1.
- R5: Source indices are: 0 to 2 for west_i bits 0 to 2, 3 to 5 for north_i bits 0 to 2, 6 and 7 for state_i bits 0 and 1, and 8+j for the output of molecule j.
- R6: Molecule m may read only sources below 8+m. An input select at or above 8+m reads west_i[0] instead.
- R7: Genotype layout: molecule m occupies bits 14m to 14m+13, with the variant at offset 0 (2 bits) and the 4-bit selects for A, B and C at offsets 2, 6 and 10. The taps for east bit k are at bit 112+4k and the taps for south bit k at bit 124+4k. Each tap is a 4-bit source index. Chained molecules feed each other through these selects.
- R8: When cfg_shift is high, a rising clock edge shifts the shadow one place toward bit 0 and writes cfg_bit into bit 135. After 136 shifts, the first bit sent sits at bit 0. If cfg_load is high in the same cycle as a shift, the active genotype takes the shadow contents from before that shift.
- R9: The outputs depend only on the active genotype. Shifting without cfg_load leaves the behaviour unchanged. After a cycle with cfg_load high, the new genotype applies from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, clears shadow and active genotype |
| cfg_bit | input | 1 | Serial genotype data |
| cfg_shift | input | 1 | Shift cfg_bit into the shadow register |
| cfg_load | input | 1 | Copy the shadow into the active genotype |
| state_i | input | 2 | Cell state; 0 is dead |
| west_i | input | 3 | Data from the west neighbour |
| north_i | input | 3 | Data from the north neighbour |
| east_o | output | 3 | Data to the east neighbour |
| south_o | output | 3 | Data to the south neighbour |

## Verification
The outputs are combinational functions of the active genotype. A corrupted active bit therefore shows on east_o or south_o in the same cycle as any input pattern that makes that bit matter. Each configuration is swept over all west values, several north values and every live state, so such a bit is exposed within one sweep. A shadow that shifts in the wrong direction, or that leaks into the active genotype early, shows as a changed output during the shift phase or as a wrong function right after the load edge.

// File: rtl/cell_eu_pkg.sv
package cell_eu_pkg;

    // Variant codes for a molecule
    typedef enum logic [1:0] {
        MOL_PLAIN = 2'b00,
        MOL_INV_B = 2'b01,
        MOL_INV_A = 2'b10,
        MOL_INV_AB = 2'b11
    } mol_fn_e;

    // C picks B (inverted when fn[0]) or A (inverted when fn[1])
    function automatic logic mol_eval(input logic [1:0] fn, input logic a,
                                      input logic b, input logic c);
        return c ? (b ^ fn[0]) : (a ^ fn[1]);
    endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
    parameter int CFG_W = 136
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bit,
    input  logic             cfg_shift,
    input  logic             cfg_load,
    output logic [CFG_W-1:0] active_o
);

    typedef struct packed {
        logic [CFG_W-1:0] shadow;
        logic [CFG_W-1:0] active;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_shift) r_d.shadow = {cfg_bit, r_q.shadow[CFG_W-1:1]};
        if (cfg_load)  r_d.active = r_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active_o = r_q.active;

    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(active_o));

    // R8
    active_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> active_o == $past(r_q.shadow));

    // R8
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> r_q.shadow[CFG_W-1] == $past(cfg_bit));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(r_q.shadow));

endmodule

// File: rtl/mol_array.sv
module mol_array
    import cell_eu_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_MOL = 8,
    parameter int SEL_W = 4,
    parameter int MOL_W = 14
) (
    input  logic [N_IN-1:0]        cell_in,
    input  logic [N_MOL*MOL_W-1:0] mol_cfg,
    output logic [N_MOL-1:0]       mol_out
);

    localparam int N_SRC = N_IN + N_MOL;

    logic [N_SRC-1:0] src;

    always_comb begin
        src = '0;
        src[N_IN-1:0] = cell_in;
        for (int m = 0; m < N_MOL; m++) begin
            logic [1:0]       fn;
            logic [SEL_W-1:0] sa, sb, sc;
            logic             a, b, c;
            fn = mol_cfg[m*MOL_W +: 2];
            sa = mol_cfg[m*MOL_W + 2 +: SEL_W];
            sb = mol_cfg[m*MOL_W + 2 + SEL_W +: SEL_W];
            sc = mol_cfg[m*MOL_W + 2 + 2*SEL_W +: SEL_W];
            // feed-forward: forbidden sources fall back to source 0
            a = (int'(sa) < N_IN + m) ? src[sa] : src[0];
            b = (int'(sb) < N_IN + m) ? src[sb] : src[0];
            c = (int'(sc) < N_IN + m) ? src[sc] : src[0];
            src[N_IN+m] = mol_eval(fn, a, b, c);
            // R4
            if (fn == MOL_INV_B && a == b && b == c) begin
                const_lo_chk: assert (src[N_IN+m] == 1'b0);
            end
            // R4
            if (fn == MOL_INV_A && a == b && b == c) begin
                const_hi_chk: assert (src[N_IN+m] == 1'b1);
            end
        end
    end

    assign mol_out = src[N_SRC-1:N_IN];

endmodule

// File: rtl/tap_route.sv
module tap_route #(
    parameter int DW    = 3,
    parameter int STW   = 2,
    parameter int N_SRC = 16,
    parameter int SEL_W = 4
) (
    input  logic [N_SRC-1:0]      src,
    input  logic [2*DW*SEL_W-1:0] taps,
    input  logic [STW-1:0]        state_i,
    input  logic [DW-1:0]         west_i,
    input  logic [DW-1:0]         north_i,
    output logic [DW-1:0]         east_o,
    output logic [DW-1:0]         south_o
);

    logic [DW-1:0] east_live, south_live;
    logic          dead;

    for (genvar k = 0; k < DW; k++) begin : g_tap
        assign east_live[k]  = src[taps[k*SEL_W +: SEL_W]];
        assign south_live[k] = src[taps[(DW+k)*SEL_W +: SEL_W]];
    end

    assign dead    = (state_i == '0);
    assign east_o  = dead ? west_i  : east_live;
    assign south_o = dead ? north_i : south_live;

endmodule

// File: rtl/cell_eu.sv
module cell_eu #(
    parameter int DW    = 3,
    parameter int STW   = 2,
    parameter int N_MOL = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_bit,
    input  logic           cfg_shift,
    input  logic           cfg_load,
    input  logic [STW-1:0] state_i,
    input  logic [DW-1:0]  west_i,
    input  logic [DW-1:0]  north_i,
    output logic [DW-1:0]  east_o,
    output logic [DW-1:0]  south_o
);

    localparam int N_IN     = 2*DW + STW;
    localparam int N_SRC    = N_IN + N_MOL;
    localparam int SEL_W    = $clog2(N_SRC);
    localparam int MOL_W    = 2 + 3*SEL_W;
    localparam int TAP_BASE = N_MOL*MOL_W;
    localparam int TAP_W    = 2*DW*SEL_W;
    localparam int CFG_W    = TAP_BASE + TAP_W;

    logic [CFG_W-1:0] geno;
    logic [N_IN-1:0]  cell_in;
    logic [N_MOL-1:0] mol_out;

    assign cell_in = {state_i, north_i, west_i};

    cfg_store #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit),
        .cfg_shift(cfg_shift), .cfg_load(cfg_load), .active_o(geno)
    );

    mol_array #(.N_IN(N_IN), .N_MOL(N_MOL), .SEL_W(SEL_W), .MOL_W(MOL_W)) u_mol (
        .cell_in(cell_in), .mol_cfg(geno[TAP_BASE-1:0]), .mol_out(mol_out)
    );

    tap_route #(.DW(DW), .STW(STW), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_tap (
        .src({mol_out, cell_in}), .taps(geno[CFG_W-1:TAP_BASE]),
        .state_i(state_i), .west_i(west_i), .north_i(north_i),
        .east_o(east_o), .south_o(south_o)
    );

    // R2
    dead_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == '0) |-> (east_o == west_i && south_o == north_i));

endmodule

// File: tb/tb_cell_eu.sv
`timescale 1ns/100ps
module tb_cell_eu;

    localparam int GW = 136;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bit = 1'b0, cfg_shift = 1'b0, cfg_load = 1'b0;
    logic [1:0] state_i = 2'd0;
    logic [2:0] west_i = 3'd0, north_i = 3'd0;
    logic [2:0] east_o, south_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [GW-1:0] m_shadow = '0;
    logic [GW-1:0] m_active = '0;

    always #2.5 clk = ~clk;

    cell_eu dut (
        .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit), .cfg_shift(cfg_shift),
        .cfg_load(cfg_load), .state_i(state_i), .west_i(west_i),
        .north_i(north_i), .east_o(east_o), .south_o(south_o)
    );

    // Behavioural model: returns {south, east}
    function automatic logic [5:0] model(input logic [GW-1:0] g, input logic [1:0] st,
                                         input logic [2:0] w, input logic [2:0] n);
        logic [15:0] s;
        logic [2:0]  e, so;
        if (st == 2'd0) return {n, w};
        s = '0;
        for (int i = 0; i < 3; i++) begin
            s[i] = w[i];
            s[3+i] = n[i];
        end
        s[6] = st[0];
        s[7] = st[1];
        for (int m = 0; m < 8; m++) begin
            int fn, ia, ib, ic;
            logic va, vb, vc, r;
            fn = int'(g[m*14 +: 2]);
            ia = int'(g[m*14+2 +: 4]);
            ib = int'(g[m*14+6 +: 4]);
            ic = int'(g[m*14+10 +: 4]);
            if (ia >= 8+m) ia = 0;
            if (ib >= 8+m) ib = 0;
            if (ic >= 8+m) ic = 0;
            va = s[ia]; vb = s[ib]; vc = s[ic];
            if (vc == 1'b0) r = (fn >= 2) ? ~va : va;
            else            r = (fn % 2 == 1) ? ~vb : vb;
            s[8+m] = r;
        end
        for (int k = 0; k < 3; k++) begin
            e[k]  = s[int'(g[112+4*k +: 4])];
            so[k] = s[int'(g[124+4*k +: 4])];
        end
        return {so, e};
    endfunction

    function automatic logic [GW-1:0] put_mol(input logic [GW-1:0] g, input int m,
                                              input int fn, input int a, input int b, input int c);
        g[m*14 +: 2]   = 2'(fn);
        g[m*14+2 +: 4] = 4'(a);
        g[m*14+6 +: 4] = 4'(b);
        g[m*14+10 +: 4] = 4'(c);
        return g;
    endfunction

    function automatic logic [GW-1:0] put_taps(input logic [GW-1:0] g,
        input int e0, input int e1, input int e2, input int s0, input int s1, input int s2);
        g[112 +: 4] = 4'(e0); g[116 +: 4] = 4'(e1); g[120 +: 4] = 4'(e2);
        g[124 +: 4] = 4'(s0); g[128 +: 4] = 4'(s1); g[132 +: 4] = 4'(s2);
        return g;
    endfunction

    // One clock: drive after falling edge, compare before the rising edge,
    // then advance the model across that rising edge.
    task automatic cyc(input logic b, input logic sh, input logic ld, input logic [1:0] st,
                       input logic [2:0] w, input logic [2:0] n, input string tag);
        logic [5:0]    exp;
        logic [GW-1:0] old;
        @(negedge clk);
        cfg_bit = b; cfg_shift = sh; cfg_load = ld;
        state_i = st; west_i = w; north_i = n;
        #1;
        exp = model(m_active, st, w, n);
        n_chk++;
        if ({south_o, east_o} !== exp) begin
            n_bad++;
            $display("FAIL %s: south/east got %b/%b expected %b/%b (st=%0d w=%b n=%b)",
                     tag, south_o, east_o, exp[5:3], exp[2:0], st, w, n);
        end
        old = m_shadow;
        if (sh) m_shadow = {b, m_shadow[GW-1:1]};
        if (ld) m_active = old;
    endtask

    task automatic sweep(input string tag, input bit dead_only);
        for (int s = 1; s < 4; s++)
            for (int w = 0; w < 8; w++)
                for (int j = 0; j < 4; j++) begin
                    logic [2:0] nv;
                    nv = 3'((w * 3 + j * 5 + s) % 8);
                    cyc(1'b0, 1'b0, 1'b0, dead_only ? 2'd0 : 2'(s), 3'(w), nv, tag);
                end
    endtask

    // Shift a genotype LSB first; outputs must not change meanwhile
    task automatic send(input logic [GW-1:0] g, input bit load_last);
        for (int i = 0; i < GW; i++)
            cyc(g[i], 1'b1, (load_last && i == GW-1), 2'(1 + i % 3),
                3'(i % 8), 3'((i / 8) % 8), "R9");
    endtask

    task automatic load_now();
        cyc(1'b0, 1'b0, 1'b1, 2'd1, 3'd5, 3'd2, "R9");
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [GW-1:0] g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset genotype, live states copy west bit 0
        sweep("R1", 1'b0);
        // R2: dead pass-through with reset genotype
        sweep("R2", 1'b1);

        // R3: each variant, A=west0 B=north0 C=west1
        g = '0;
        for (int m = 0; m < 4; m++) g = put_mol(g, m, m, 0, 3, 1);
        g = put_taps(g, 8, 9, 10, 11, 3, 6);
        send(g, 1'b0); load_now();
        sweep("R3", 1'b0);

        // R4: constants from molecules with tied inputs
        g = '0;
        g = put_mol(g, 0, 1, 1, 1, 1);
        g = put_mol(g, 1, 2, 4, 4, 4);
        g = put_mol(g, 2, 1, 6, 6, 6);
        g = put_mol(g, 3, 2, 7, 7, 7);
        g = put_taps(g, 8, 9, 10, 11, 8, 9);
        send(g, 1'b0); load_now();
        sweep("R4", 1'b0);

        // R6: selects at or above own index read west bit 0
        g = '0;
        g = put_mol(g, 0, 0, 9, 12, 8);
        g = put_mol(g, 1, 3, 9, 2, 5);
        g = put_mol(g, 4, 1, 2, 5, 11);
        g = put_mol(g, 5, 0, 12, 15, 15);
        g = put_taps(g, 8, 9, 13, 2, 5, 12);
        send(g, 1'b0); load_now();
        sweep("R6", 1'b0);

        // R5: taps straight onto cell inputs
        g = '0;
        g = put_taps(g, 3, 4, 5, 6, 7, 0);
        send(g, 1'b0); load_now();
        sweep("R5", 1'b0);

        // R7: deep chain through all molecules
        g = '0;
        g = put_mol(g, 0, 0, 0, 3, 7);
        g = put_mol(g, 1, 1, 8, 1, 4);
        g = put_mol(g, 2, 2, 9, 8, 2);
        g = put_mol(g, 3, 3, 10, 9, 5);
        g = put_mol(g, 4, 0, 11, 10, 6);
        g = put_mol(g, 5, 1, 12, 11, 9);
        g = put_mol(g, 6, 2, 13, 12, 0);
        g = put_mol(g, 7, 3, 14, 13, 10);
        g = put_taps(g, 15, 14, 13, 12, 11, 10);
        send(g, 1'b0);
        // R9: shifted but not loaded, old behaviour must remain
        sweep("R9", 1'b0);
        load_now();
        sweep("R7", 1'b0);
        // R2: dead pass-through with a busy genotype loaded
        sweep("R2", 1'b1);

        // R8: load on the last shift captures the pre-shift shadow
        g = '0;
        g = put_mol(g, 0, 2, 3, 0, 6);
        g = put_taps(g, 8, 1, 8, 4, 8, 7);
        g[GW-1] = 1'b1;
        send(g, 1'b1);
        sweep("R8", 1'b0);
        load_now();
        sweep("R8", 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule